// File: doc/BRIEF.md
# Dual-PLL Power-Up Sequencer

This block orders the start-up of a clock generator that has two PLLs. A 10 MHz timebase clocks it. The supply comparators, the crystal amplitude detector and the analog loops are outside the block; they appear only as digital flags. The sequence is fixed. The block first holds everything in reset until the supplies are good and power-down is released. If a crystal is used, it then waits for sufficient crystal swing. After that it runs four phases for the first PLL and then the same four for the second:

- a programmable calibration period;
- a programmable VCO settle period;
- a wait for the synchronized lock flag;
- a wait for one phase-detector strobe, which clears that loop's loss-of-lock flag.

Each loop's outputs are enabled as soon as its calibration ends, without waiting for lock. Lock and crystal flags pass through two-flop synchronizers. The phase-detector strobes are single-cycle pulses synchronous to the timebase. The four period counts are captured when the sequence leaves its reset step. Two status pins can each be routed to either loss-of-lock flag. A 4-bit step code shows progress.

Top module: `dual_pll_sequencer`

## Requirements
- R1: While `porGood` or `pdnRelease` is low, the block holds `stepCode` at 1. In that state all calibration and output enables are low, and both `lol1` and `lol2` are high.
- R2: If `porGood` or `pdnRelease` falls at any later step, the next clock edge returns `stepCode` to 1. That same edge clears every enable and sets both loss-of-lock flags.
- R3: Step 2 waits for the crystal. With `xtalUsed` high, the block stays there until `xtalAmpOk` has passed its two-flop synchronizer; step 3 then begins on the third edge after `xtalAmpOk` rises. With `xtalUsed` low, step 2 lasts one cycle.
- R4: In step 3, `calEn1` is high for exactly the latched first calibration count of cycles. In step 7, `calEn2` is high for exactly the latched second calibration count. A count of zero acts as one.
- R5: Step 4 lasts the latched first VCO count of cycles, and step 8 lasts the latched second VCO count. `outEn1` rises on entry to step 4, and `outEn2` rises on entry to step 8. Each enable then stays high until reset.
- R6: In step 6, `lol1` falls on the first `pfdTick1` that arrives while the synchronized `pllLock1` is high. A `pfdTick1` that arrives while lock is low leaves `lol1` high and the step unchanged. The same rule holds for `lol2`, `pfdTick2` and `pllLock2` in step 10.
- R7: The second PLL's phases start only after `lol1` has cleared. `calEn1` and `calEn2` are never high together, and `outEn2` high implies `outEn1` high.
- R8: The four period counts are captured on the edge that leaves step 1. Later changes on the count inputs do not affect the running sequence.
- R9: Each status pin follows its own select bit: 0 routes `lol1` to the pin and 1 routes `lol2`.
- R10: `stepCode` numbers the steps as follows: 1 reset, 2 crystal, 3 calibration 1, 4 VCO 1, 5 lock 1, 6 lock-flag release 1, 7 to 10 the same four phases for the second PLL, and 11 done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 10 MHz timebase |
| rst_n | input | 1 | asynchronous active-low reset |
| porGood | input | 1 | supplies above threshold |
| pdnRelease | input | 1 | power-down released |
| xtalUsed | input | 1 | crystal selected as reference |
| xtalAmpOk | input | 1 | crystal swing sufficient (asynchronous) |
| pllLock1 | input | 1 | first loop locked (asynchronous) |
| pllLock2 | input | 1 | second loop locked (asynchronous) |
| pfdTick1 | input | 1 | one-cycle phase-detector strobe, first loop |
| pfdTick2 | input | 1 | one-cycle phase-detector strobe, second loop |
| calCount1 | input | CNT_W | calibration cycles, first loop |
| vcoCount1 | input | CNT_W | VCO settle cycles, first loop |
| calCount2 | input | CNT_W | calibration cycles, second loop |
| vcoCount2 | input | CNT_W | VCO settle cycles, second loop |
| statusSel0 | input | 1 | source select for status0 |
| statusSel1 | input | 1 | source select for status1 |
| calEn1 | output | 1 | calibration enable, first loop |
| calEn2 | output | 1 | calibration enable, second loop |
| outEn1 | output | 1 | output enable, first loop |
| outEn2 | output | 1 | output enable, second loop |
| lol1 | output | 1 | loss-of-lock, first loop |
| lol2 | output | 1 | loss-of-lock, second loop |
| status0 | output | 1 | routed loss-of-lock flag |
| status1 | output | 1 | routed loss-of-lock flag |
| stepCode | output | 4 | current step, 1 to 11 |

## Verification
On every cycle, the assertions check four things:

- the return to step 1 one edge after a supply or power-down drop;
- the mutual exclusion of the calibration enables and the order of the output enables;
- that each output enable rises only straight out of calibration;
- that a loss-of-lock flag falls only after its strobe, in its release step.

The exact lengths of the calibration and settle periods, the three-edge crystal latency, the capture of counts at sequence start, the lock gating of the strobe and the status routing depend on chosen stimulus. Only the directed scenarios show these.

// File: rtl/dual_pll_sequencer_pkg.sv
package dual_pll_sequencer_pkg;

  typedef enum logic [3:0] {
    ST_POWER = 4'd1,
    ST_XTAL  = 4'd2,
    ST_CAL1  = 4'd3,
    ST_VCO1  = 4'd4,
    ST_LOCK1 = 4'd5,
    ST_LOL1  = 4'd6,
    ST_CAL2  = 4'd7,
    ST_VCO2  = 4'd8,
    ST_LOCK2 = 4'd9,
    ST_LOL2  = 4'd10,
    ST_RUN   = 4'd11
  } seqStep_e;

  typedef enum logic [1:0] {
    SEL_CAL1 = 2'd0,
    SEL_VCO1 = 2'd1,
    SEL_CAL2 = 2'd2,
    SEL_VCO2 = 2'd3
  } timerSel_e;

  typedef struct packed {
    logic      latchCounts;
    logic      timerClr;
    timerSel_e timerSel;
  } seqCtl_t;

endpackage

// File: rtl/dual_pll_sequencer_sync.sv
module dual_pll_sequencer_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  localparam int LAST = STAGES - 1;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], asyncIn[b]};
    end
    assign syncOut[b] = chain[LAST];
  end
endmodule

// File: rtl/dual_pll_sequencer_dp.sv
module dual_pll_sequencer_dp
  import dual_pll_sequencer_pkg::*;
#(
  parameter int CNT_W  = 22,
  parameter int N_CNTS = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  seqCtl_t                     ctl,
  input  logic [N_CNTS-1:0][CNT_W-1:0] cfgCounts,
  output logic                        timerDone
);
  localparam int EXT_W = CNT_W + 1;

  logic [N_CNTS-1:0][CNT_W-1:0] heldCounts;
  logic [CNT_W-1:0]             tick;
  logic [CNT_W-1:0]             target;
  logic [CNT_W-1:0]             effTarget;
  logic [EXT_W-1:0]             tickNext;

  // capture every programmed count at sequence start
  for (genvar i = 0; i < N_CNTS; i++) begin : g_hold
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               heldCounts[i] <= '0;
      else if (ctl.latchCounts) heldCounts[i] <= cfgCounts[i];
    end
  end

  // period counter, cleared on every step change
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            tick <= '0;
    else if (ctl.timerClr) tick <= '0;
    else if (tick != '1)   tick <= tick + 1'b1;
  end

  always_comb begin
    target    = heldCounts[ctl.timerSel];
    effTarget = (target == '0) ? {{(CNT_W-1){1'b0}}, 1'b1} : target;
    tickNext  = {1'b0, tick} + 1'b1;
    timerDone = (tickNext >= {1'b0, effTarget});
  end
endmodule

// File: rtl/dual_pll_sequencer_ctrl.sv
module dual_pll_sequencer_ctrl
  import dual_pll_sequencer_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     supplyOk,
  input  logic     xtalUsed,
  input  logic     ampSync,
  input  logic     lockSync1,
  input  logic     lockSync2,
  input  logic     pfdTick1,
  input  logic     pfdTick2,
  input  logic     timerDone,
  output seqStep_e state,
  output seqCtl_t  ctl,
  output logic     lolFlag1,
  output logic     lolFlag2
);
  seqStep_e nextState;

  always_comb begin
    nextState = state;
    if (!supplyOk) begin
      nextState = ST_POWER;
    end else begin
      unique case (state)
        ST_POWER: nextState = ST_XTAL;
        ST_XTAL:  if (!xtalUsed || ampSync) nextState = ST_CAL1;
        ST_CAL1:  if (timerDone) nextState = ST_VCO1;
        ST_VCO1:  if (timerDone) nextState = ST_LOCK1;
        ST_LOCK1: if (lockSync1) nextState = ST_LOL1;
        ST_LOL1: begin
          if (!lockSync1)    nextState = ST_LOCK1;
          else if (pfdTick1) nextState = ST_CAL2;
        end
        ST_CAL2:  if (timerDone) nextState = ST_VCO2;
        ST_VCO2:  if (timerDone) nextState = ST_LOCK2;
        ST_LOCK2: if (lockSync2) nextState = ST_LOL2;
        ST_LOL2: begin
          if (!lockSync2)    nextState = ST_LOCK2;
          else if (pfdTick2) nextState = ST_RUN;
        end
        ST_RUN:   nextState = ST_RUN;
        default:  nextState = ST_POWER;
      endcase
    end
  end

  always_comb begin
    ctl.latchCounts = (state == ST_POWER) && supplyOk;
    ctl.timerClr    = (nextState != state);
    unique case (state)
      ST_VCO1: ctl.timerSel = SEL_VCO1;
      ST_CAL2: ctl.timerSel = SEL_CAL2;
      ST_VCO2: ctl.timerSel = SEL_VCO2;
      default: ctl.timerSel = SEL_CAL1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_POWER;
    else        state <= nextState;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lolFlag1 <= 1'b1;
      lolFlag2 <= 1'b1;
    end else if (!supplyOk || state == ST_POWER) begin
      lolFlag1 <= 1'b1;
      lolFlag2 <= 1'b1;
    end else begin
      if (state == ST_LOL1 && lockSync1 && pfdTick1) lolFlag1 <= 1'b0;
      if (state == ST_LOL2 && lockSync2 && pfdTick2) lolFlag2 <= 1'b0;
    end
  end
endmodule

// File: rtl/dual_pll_sequencer.sv
module dual_pll_sequencer
  import dual_pll_sequencer_pkg::*;
#(
  parameter int CNT_W = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             porGood,
  input  logic             pdnRelease,
  input  logic             xtalUsed,
  input  logic             xtalAmpOk,
  input  logic             pllLock1,
  input  logic             pllLock2,
  input  logic             pfdTick1,
  input  logic             pfdTick2,
  input  logic [CNT_W-1:0] calCount1,
  input  logic [CNT_W-1:0] vcoCount1,
  input  logic [CNT_W-1:0] calCount2,
  input  logic [CNT_W-1:0] vcoCount2,
  input  logic             statusSel0,
  input  logic             statusSel1,
  output logic             calEn1,
  output logic             calEn2,
  output logic             outEn1,
  output logic             outEn2,
  output logic             lol1,
  output logic             lol2,
  output logic             status0,
  output logic             status1,
  output logic [3:0]       stepCode
);
  localparam int N_CNTS = 4;
  localparam int N_SYNC = 3;

  logic [N_SYNC-1:0]            syncRaw;
  logic [N_SYNC-1:0]            syncVal;
  logic [N_CNTS-1:0][CNT_W-1:0] cfgCounts;
  seqCtl_t                      ctl;
  seqStep_e                     state;
  logic                         timerDone;
  logic                         supplyOk;

  assign supplyOk = porGood && pdnRelease;
  assign syncRaw  = {pllLock2, pllLock1, xtalAmpOk};

  assign cfgCounts[SEL_CAL1] = calCount1;
  assign cfgCounts[SEL_VCO1] = vcoCount1;
  assign cfgCounts[SEL_CAL2] = calCount2;
  assign cfgCounts[SEL_VCO2] = vcoCount2;

  dual_pll_sequencer_sync #(.WIDTH(N_SYNC), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .asyncIn(syncRaw), .syncOut(syncVal)
  );

  dual_pll_sequencer_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .supplyOk(supplyOk), .xtalUsed(xtalUsed),
    .ampSync(syncVal[0]), .lockSync1(syncVal[1]), .lockSync2(syncVal[2]),
    .pfdTick1(pfdTick1), .pfdTick2(pfdTick2), .timerDone(timerDone),
    .state(state), .ctl(ctl), .lolFlag1(lol1), .lolFlag2(lol2)
  );

  dual_pll_sequencer_dp #(.CNT_W(CNT_W), .N_CNTS(N_CNTS)) u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .cfgCounts(cfgCounts),
    .timerDone(timerDone)
  );

  assign calEn1   = (state == ST_CAL1);
  assign calEn2   = (state == ST_CAL2);
  assign outEn1   = (state >= ST_VCO1) && (state <= ST_RUN);
  assign outEn2   = (state >= ST_VCO2) && (state <= ST_RUN);
  assign status0  = statusSel0 ? lol2 : lol1;
  assign status1  = statusSel1 ? lol2 : lol1;
  assign stepCode = state;
endmodule

// File: rtl/dual_pll_sequencer_chk.sv
module dual_pll_sequencer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       porGood,
  input logic       pdnRelease,
  input logic       pfdTick1,
  input logic       pfdTick2,
  input logic       calEn1,
  input logic       calEn2,
  input logic       outEn1,
  input logic       outEn2,
  input logic       lol1,
  input logic       lol2,
  input logic [3:0] stepCode
);
  // R2
  supply_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(porGood && pdnRelease) |=> (stepCode == 4'd1 && !calEn1 && !calEn2 &&
                                  !outEn1 && !outEn2 && lol1 && lol2));

  // R7
  cal_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(calEn1 && calEn2));

  // R7
  out_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outEn2 |-> outEn1);

  // R5
  out1_after_cal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(outEn1) |-> $past(calEn1));

  // R5
  out2_after_cal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(outEn2) |-> $past(calEn2));

  // R6
  lol1_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lol1) |-> ($past(pfdTick1) && $past(stepCode) == 4'd6));

  // R6
  lol2_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lol2) |-> ($past(pfdTick2) && $past(stepCode) == 4'd10));
endmodule

bind dual_pll_sequencer dual_pll_sequencer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .porGood(porGood), .pdnRelease(pdnRelease),
  .pfdTick1(pfdTick1), .pfdTick2(pfdTick2), .calEn1(calEn1), .calEn2(calEn2),
  .outEn1(outEn1), .outEn2(outEn2), .lol1(lol1), .lol2(lol2),
  .stepCode(stepCode)
);

// File: tb/dual_pll_sequencer_test.sv
module dual_pll_sequencer_test;
  localparam int CNT_W = 22;

  logic clk = 1'b0;
  logic rst_n, porGood, pdnRelease, xtalUsed, xtalAmpOk;
  logic pllLock1, pllLock2, pfdTick1, pfdTick2, statusSel0, statusSel1;
  logic [CNT_W-1:0] calCount1, vcoCount1, calCount2, vcoCount2;
  logic calEn1, calEn2, outEn1, outEn2, lol1, lol2, status0, status1;
  logic [3:0] stepCode;

  int total = 0;
  int fails = 0;

  always #10 clk = ~clk;

  dual_pll_sequencer #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .porGood(porGood), .pdnRelease(pdnRelease),
    .xtalUsed(xtalUsed), .xtalAmpOk(xtalAmpOk), .pllLock1(pllLock1),
    .pllLock2(pllLock2), .pfdTick1(pfdTick1), .pfdTick2(pfdTick2),
    .calCount1(calCount1), .vcoCount1(vcoCount1), .calCount2(calCount2),
    .vcoCount2(vcoCount2), .statusSel0(statusSel0), .statusSel1(statusSel1),
    .calEn1(calEn1), .calEn2(calEn2), .outEn1(outEn1), .outEn2(outEn2),
    .lol1(lol1), .lol2(lol2), .status0(status0), .status1(status1),
    .stepCode(stepCode)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  // all input changes happen at the falling edge
  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n = 1'b0; porGood = 1'b0; pdnRelease = 1'b0;
    xtalUsed = 1'b0; xtalAmpOk = 1'b0;
    pllLock1 = 1'b1; pllLock2 = 1'b1; pfdTick1 = 1'b0; pfdTick2 = 1'b0;
    statusSel0 = 1'b0; statusSel1 = 1'b1;
    calCount1 = 5; vcoCount1 = 3; calCount2 = 7; vcoCount2 = 4;
    cyc(3);
    rst_n = 1'b1;
    cyc(3);
  endtask

  task automatic waitStep(input int code);
    int n = 0;
    while (stepCode != code && n < 1000) begin n++; cyc(1); end
  endtask

  task automatic countStep(input int code, output int n);
    n = 0;
    while (stepCode == code && n < 1000) begin n++; cyc(1); end
  endtask

  task automatic pulsePfd(input int which);
    if (which == 1) pfdTick1 = 1'b1; else pfdTick2 = 1'b1;
    cyc(1);
    pfdTick1 = 1'b0; pfdTick2 = 1'b0;
  endtask

  task automatic tResetHold();
    doReset();
    chk("R1 step", stepCode, 1);
    chk("R1 enables", {calEn1, calEn2, outEn1, outEn2}, 0);
    chk("R1 lol", {lol1, lol2}, 3);
    porGood = 1'b1;             // power-down still active
    cyc(5);
    chk("R1 pdn hold step", stepCode, 1);
  endtask

  task automatic tMainFlow();
    int n;
    doReset();
    porGood = 1'b1; pdnRelease = 1'b1;
    cyc(1);
    chk("R10 leaves reset step", stepCode, 2);
    cyc(1);
    chk("R3 no crystal skip", stepCode, 3);
    countStep(3, n);
    chk("R4 cal1 length", n, 5);
    chk("R5 outEn1 at step4", outEn1, 1);
    countStep(4, n);
    chk("R5 vco1 length", n, 3);
    waitStep(6);
    cyc(4);
    chk("R6 lol1 held without strobe", lol1, 1);
    chk("R7 pll2 not started", {calEn2, outEn2}, 0);
    pulsePfd(1);
    chk("R6 lol1 cleared", lol1, 0);
    chk("R10 step after release", stepCode, 7);
    statusSel0 = 1'b0; statusSel1 = 1'b1; #1;
    chk("R9 status0 from lol1", status0, 0);
    chk("R9 status1 from lol2", status1, 1);
    statusSel0 = 1'b1; statusSel1 = 1'b0; #1;
    chk("R9 swapped status0", status0, 1);
    chk("R9 swapped status1", status1, 0);
    countStep(7, n);
    chk("R4 cal2 length", n, 7);
    chk("R5 outEn2 at step8", outEn2, 1);
    countStep(8, n);
    chk("R5 vco2 length", n, 4);
    waitStep(10);
    pulsePfd(2);
    chk("R6 lol2 cleared", lol2, 0);
    chk("R10 done code", stepCode, 11);
    chk("R5 enables stay", {outEn1, outEn2}, 3);
  endtask

  task automatic tCrystalLatch();
    int n;
    doReset();
    xtalUsed = 1'b1; calCount1 = 6;
    porGood = 1'b1; pdnRelease = 1'b1;
    cyc(2);
    calCount1 = 20;             // changed after capture
    cyc(40);
    chk("R3 crystal stall", stepCode, 2);
    chk("R3 no cal during stall", calEn1, 0);
    xtalAmpOk = 1'b1;
    cyc(2);
    chk("R3 still synchronizing", stepCode, 2);
    cyc(1);
    chk("R3 cal after sync", stepCode, 3);
    countStep(3, n);
    chk("R8 captured count used", n, 6);
  endtask

  task automatic tZeroCount();
    int n;
    doReset();
    calCount1 = 0;
    porGood = 1'b1; pdnRelease = 1'b1;
    waitStep(3);
    countStep(3, n);
    chk("R4 zero count acts as one", n, 1);
  endtask

  task automatic tLockGate();
    doReset();
    pllLock1 = 1'b0;
    porGood = 1'b1; pdnRelease = 1'b1;
    waitStep(5);
    pulsePfd(1);
    cyc(2);
    chk("R6 strobe ignored without lock", lol1, 1);
    chk("R6 step held at lock wait", stepCode, 5);
    pllLock1 = 1'b1;
    waitStep(6);
    pulsePfd(1);
    chk("R6 release after lock", lol1, 0);
  endtask

  task automatic tDrop();
    doReset();
    porGood = 1'b1; pdnRelease = 1'b1;
    waitStep(6);
    pulsePfd(1);
    waitStep(8);
    porGood = 1'b0;
    cyc(1);
    chk("R2 por drop step", stepCode, 1);
    chk("R2 por drop enables", {calEn1, calEn2, outEn1, outEn2}, 0);
    chk("R2 por drop lol", {lol1, lol2}, 3);
    porGood = 1'b1;
    waitStep(3);
    pdnRelease = 1'b0;
    cyc(1);
    chk("R2 pdn drop step", stepCode, 1);
    chk("R2 pdn drop calEn1", calEn1, 0);
  endtask

  initial begin
    tResetHold();
    tMainFlow();
    tCrystalLatch();
    tZeroCount();
    tLockGate();
    tDrop();
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end
endmodule